// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block updates a soft processor's control registers in the one clock edge that takes an exception. Each request is a strobe that carries a 5-bit cause code, an exception class, the PC of the faulting instruction and the faulting data address. Two vector addresses are configuration inputs: a general exception vector and a fast TLB-refill vector. On the edge that accepts a request, the block updates the processor status word, the saved-status registers, the cause register, the TLB miscellaneous register, the bad-address register and the two link registers. On the same edge it registers the address where fetch resumes, together with a one-cycle valid pulse.

The exception-handler-active bit in status decides whether a fault is nested. A nested fault does not overwrite the saved status or the link register. A nested TLB miss counts as a double miss and goes to the general vector, not the refill vector. Break exceptions use a separate saved-status register and a separate link register. The return instructions are outside this block. A single restore input stands in for them: it copies the saved status back into status.

Top module: `exc_entry_seq`

## Requirements
- R1: Class codes on `exc_class`: 0 interrupt, 1 TLB miss, 2 TLB permission, 3 supervisor-only, 4 trap or illegal instruction, 5 break, 6 misaligned access, 7 unknown. Status bits by default: bit 0 PIE (interrupt enable), bit 1 U (user mode), bit 2 EH (handler active), bit 3 IH (interrupt handler). Classes 1 to 5 set EH and clear PIE and U.
- R2: An interrupt is accepted only while PIE is 1. When accepted, it copies status to estatus, sets IH, clears PIE and U, leaves EH alone, loads PC+4 into EA and vectors to the general address. When PIE is 0, an interrupt changes no register and raises no valid pulse.
- R3: Every accepted class from 0 to 5 writes the cause code into bits [6:2] of the cause register and leaves its other bits as they were.
- R4: A TLB miss while EH is 0 copies status to estatus and PC+4 to EA. It sets TLB-misc WR (bit 3), clears TLB-misc DBL (bit 2) and vectors to the refill address.
- R5: A TLB miss while EH is 1 leaves estatus and EA unchanged, sets DBL and vectors to the general address.
- R6: Supervisor-only, trap and illegal exceptions save status to estatus and PC+4 to EA only when EH was 0. They always vector to the general address.
- R7: A break saves status to bstatus and PC+4 to BA only when EH was 0. It leaves estatus and EA unchanged and vectors to the general address.
- R8: A TLB permission fault always saves status to estatus and PC+4 to EA, and leaves the TLB-misc register unchanged.
- R9: A misaligned access loads the fault address into the bad-address register and sets the whole cause register to the cause code shifted left by 2. Status is unchanged, and the block vectors to the general address.
- R10: A request of class 7 changes no register and pulses `class_err` for one cycle.
- R11: `restore` copies estatus into status. When it arrives together with an accepted exception, the exception wins.
- R12: All register updates and the `next_pc`/`next_pc_valid` result appear after the single clock edge that samples the request. `next_pc_valid` lasts one cycle. Synchronous reset loads status with STATUS_RST (default 3) and clears everything else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception request strobe |
| exc_class | input | 3 | Exception class code |
| exc_cause | input | 5 | Cause code |
| cur_pc | input | 32 | PC of the excepting instruction |
| fault_addr | input | 32 | Faulting data address |
| vec_general | input | 32 | General exception vector |
| vec_tlb_fast | input | 32 | Fast TLB-refill vector |
| restore | input | 1 | Copy estatus back to status |
| status_q | output | 32 | Status register |
| estatus_q | output | 32 | Exception saved status |
| bstatus_q | output | 32 | Break saved status |
| cause_q | output | 32 | Exception cause register |
| tlbmisc_q | output | 32 | TLB miscellaneous register |
| badaddr_q | output | 32 | Bad-address register |
| ea_q | output | 32 | Exception link register |
| ba_q | output | 32 | Break link register |
| next_pc | output | 32 | Resume fetch address |
| next_pc_valid | output | 1 | One-cycle pulse marking next_pc |
| class_err | output | 1 | One-cycle pulse for an unknown class |

## Verification
Every result of a request is registered exactly once. The status, saved-status, cause, TLB-misc, bad-address and link registers, `next_pc`, `next_pc_valid` and `class_err` are all due on the first rising edge after the request is presented. The bench drives each request on a falling edge and holds it for one cycle. It samples every output on the next falling edge, half a cycle after the register updates. Because `next_pc_valid` and `class_err` are pulses, the vector walk also checks that they are low on rows that must not produce them. A directed idle cycle confirms that the pulse has ended.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CAUSE_W   = 5;
    localparam int CAUSE_LSB = 2;
    localparam int CLASS_W   = 3;

    typedef enum logic [CLASS_W-1:0] {
        EXC_IRQ      = 3'd0,
        EXC_TLB_MISS = 3'd1,
        EXC_TLB_PERM = 3'd2,
        EXC_SUPER    = 3'd3,
        EXC_TRAP     = 3'd4,
        EXC_BREAK    = 3'd5,
        EXC_UNALIGN  = 3'd6,
        EXC_UNKNOWN  = 3'd7
    } exc_class_e;

    // What the decoder asks the register units to do on this edge
    typedef struct packed {
        logic take;        // request accepted, vector produced
        logic save_est;    // estatus <= status
        logic save_ea;     // EA <= PC+4
        logic save_bst;    // bstatus <= status
        logic save_ba;     // BA <= PC+4
        logic set_eh;
        logic set_ih;
        logic clr_pie_u;
        logic wr_cause;    // cause field only
        logic whole_cause; // whole cause register
        logic set_wr;
        logic clr_dbl;
        logic set_dbl;
        logic load_bad;
        logic fast_vec;
        logic err;
    } exc_action_t;

    function automatic logic [31:0] link_addr(input logic [31:0] pc);
        return pc + 32'd4;
    endfunction

endpackage

// File: rtl/exc_decode.sv
module exc_decode
    import exc_entry_pkg::*;
(
    input  logic                   req_valid,
    input  logic [CLASS_W-1:0]     req_class,
    input  logic                   eh_now,
    input  logic                   pie_now,
    output exc_action_t            act
);

    exc_class_e cls;
    assign cls = exc_class_e'(req_class);

    always_comb begin
        act = '0;
        if (req_valid) begin
            unique case (cls)
                EXC_IRQ: begin
                    if (pie_now) begin
                        act.take      = 1'b1;
                        act.save_est  = 1'b1;
                        act.save_ea   = 1'b1;
                        act.set_ih    = 1'b1;
                        act.clr_pie_u = 1'b1;
                        act.wr_cause  = 1'b1;
                    end
                end
                EXC_TLB_MISS: begin
                    act.take      = 1'b1;
                    act.set_eh    = 1'b1;
                    act.clr_pie_u = 1'b1;
                    act.wr_cause  = 1'b1;
                    if (!eh_now) begin
                        act.save_est = 1'b1;
                        act.save_ea  = 1'b1;
                        act.set_wr   = 1'b1;
                        act.clr_dbl  = 1'b1;
                        act.fast_vec = 1'b1;
                    end else begin
                        act.set_dbl  = 1'b1;
                    end
                end
                EXC_TLB_PERM: begin
                    // WR would need EH clear after entry; entry always sets EH
                    act.take      = 1'b1;
                    act.save_est  = 1'b1;
                    act.save_ea   = 1'b1;
                    act.set_eh    = 1'b1;
                    act.clr_pie_u = 1'b1;
                    act.wr_cause  = 1'b1;
                end
                EXC_SUPER, EXC_TRAP: begin
                    act.take      = 1'b1;
                    act.save_est  = !eh_now;
                    act.save_ea   = !eh_now;
                    act.set_eh    = 1'b1;
                    act.clr_pie_u = 1'b1;
                    act.wr_cause  = 1'b1;
                end
                EXC_BREAK: begin
                    act.take      = 1'b1;
                    act.save_bst  = !eh_now;
                    act.save_ba   = !eh_now;
                    act.set_eh    = 1'b1;
                    act.clr_pie_u = 1'b1;
                    act.wr_cause  = 1'b1;
                end
                EXC_UNALIGN: begin
                    act.take        = 1'b1;
                    act.whole_cause = 1'b1;
                    act.load_bad    = 1'b1;
                end
                default: begin
                    act.err = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
    import exc_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          BIT_PIE    = 0,
    parameter int          BIT_U      = 1,
    parameter int          BIT_EH     = 2,
    parameter int          BIT_IH     = 3,
    parameter logic [31:0] STATUS_RST = 32'h3
) (
    input  logic            clk,
    input  logic            rst,
    input  exc_action_t     act,
    input  logic            restore,
    output logic [XLEN-1:0] status_q,
    output logic [XLEN-1:0] estatus_q,
    output logic [XLEN-1:0] bstatus_q
);

    logic [XLEN-1:0] status_n;

    always_comb begin
        status_n = status_q;
        if (act.take) begin
            if (act.set_eh)    status_n[BIT_EH]  = 1'b1;
            if (act.set_ih)    status_n[BIT_IH]  = 1'b1;
            if (act.clr_pie_u) begin
                status_n[BIT_PIE] = 1'b0;
                status_n[BIT_U]   = 1'b0;
            end
        end else if (restore) begin
            status_n = estatus_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= STATUS_RST[XLEN-1:0];
            estatus_q <= '0;
            bstatus_q <= '0;
        end else begin
            status_q <= status_n;
            if (act.save_est) estatus_q <= status_q;
            if (act.save_bst) bstatus_q <= status_q;
        end
    end

    AST_ENTRY_SETS_EH: assert property (@(posedge clk) disable iff (rst)
        act.take && act.set_eh |=> status_q[BIT_EH] && !status_q[BIT_PIE] && !status_q[BIT_U]); // R1

    AST_IRQ_SETS_IH: assert property (@(posedge clk) disable iff (rst)
        act.take && act.set_ih |=> status_q[BIT_IH] && !status_q[BIT_PIE]); // R2

    AST_RESTORE_COPY: assert property (@(posedge clk) disable iff (rst)
        restore && !act.take |=> status_q == $past(estatus_q)); // R11

endmodule

// File: rtl/exc_fault_regs.sv
module exc_fault_regs
    import exc_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int BIT_WR  = 3,
    parameter int BIT_DBL = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  exc_action_t         act,
    input  logic [CAUSE_W-1:0]  cause,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     addr,
    input  logic [XLEN-1:0]     vec_gen,
    input  logic [XLEN-1:0]     vec_fast,
    output logic [XLEN-1:0]     cause_q,
    output logic [XLEN-1:0]     tlbmisc_q,
    output logic [XLEN-1:0]     badaddr_q,
    output logic [XLEN-1:0]     ea_q,
    output logic [XLEN-1:0]     ba_q,
    output logic [XLEN-1:0]     npc_q,
    output logic                npc_vld_q,
    output logic                err_q
);

    localparam int CAUSE_MSB = CAUSE_LSB + CAUSE_W - 1;

    logic [XLEN-1:0] cause_n;
    logic [XLEN-1:0] tlbmisc_n;
    logic [XLEN-1:0] link;

    assign link = link_addr(pc);

    always_comb begin
        cause_n = cause_q;
        if (act.whole_cause) begin
            cause_n = '0;
            cause_n[CAUSE_MSB:CAUSE_LSB] = cause;
        end else if (act.wr_cause) begin
            cause_n[CAUSE_MSB:CAUSE_LSB] = cause;
        end
    end

    always_comb begin
        tlbmisc_n = tlbmisc_q;
        if (act.clr_dbl) tlbmisc_n[BIT_DBL] = 1'b0;
        if (act.set_dbl) tlbmisc_n[BIT_DBL] = 1'b1;
        if (act.set_wr)  tlbmisc_n[BIT_WR]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q   <= '0;
            tlbmisc_q <= '0;
            badaddr_q <= '0;
            ea_q      <= '0;
            ba_q      <= '0;
            npc_q     <= '0;
            npc_vld_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            cause_q   <= cause_n;
            tlbmisc_q <= tlbmisc_n;
            if (act.load_bad) badaddr_q <= addr;
            if (act.save_ea)  ea_q      <= link;
            if (act.save_ba)  ba_q      <= link;
            if (act.take)     npc_q     <= act.fast_vec ? vec_fast : vec_gen;
            npc_vld_q <= act.take;
            err_q     <= act.err;
        end
    end

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(npc_vld_q && err_q)); // R10

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        npc_vld_q && !act.take |=> !npc_vld_q); // R12

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          BIT_PIE    = 0,
    parameter int          BIT_U      = 1,
    parameter int          BIT_EH     = 2,
    parameter int          BIT_IH     = 3,
    parameter int          BIT_WR     = 3,
    parameter int          BIT_DBL    = 2,
    parameter logic [31:0] STATUS_RST = 32'h3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                exc_valid,
    input  logic [2:0]          exc_class,
    input  logic [4:0]          exc_cause,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic [XLEN-1:0]     fault_addr,
    input  logic [XLEN-1:0]     vec_general,
    input  logic [XLEN-1:0]     vec_tlb_fast,
    input  logic                restore,
    output logic [XLEN-1:0]     status_q,
    output logic [XLEN-1:0]     estatus_q,
    output logic [XLEN-1:0]     bstatus_q,
    output logic [XLEN-1:0]     cause_q,
    output logic [XLEN-1:0]     tlbmisc_q,
    output logic [XLEN-1:0]     badaddr_q,
    output logic [XLEN-1:0]     ea_q,
    output logic [XLEN-1:0]     ba_q,
    output logic [XLEN-1:0]     next_pc,
    output logic                next_pc_valid,
    output logic                class_err
);

    exc_action_t act;

    exc_decode u_dec (
        .req_valid (exc_valid),
        .req_class (exc_class),
        .eh_now    (status_q[BIT_EH]),
        .pie_now   (status_q[BIT_PIE]),
        .act       (act)
    );

    exc_status_regs #(
        .XLEN(XLEN), .BIT_PIE(BIT_PIE), .BIT_U(BIT_U),
        .BIT_EH(BIT_EH), .BIT_IH(BIT_IH), .STATUS_RST(STATUS_RST)
    ) u_st (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .restore   (restore),
        .status_q  (status_q),
        .estatus_q (estatus_q),
        .bstatus_q (bstatus_q)
    );

    exc_fault_regs #(
        .XLEN(XLEN), .BIT_WR(BIT_WR), .BIT_DBL(BIT_DBL)
    ) u_flt (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .cause     (exc_cause),
        .pc        (cur_pc),
        .addr      (fault_addr),
        .vec_gen   (vec_general),
        .vec_fast  (vec_tlb_fast),
        .cause_q   (cause_q),
        .tlbmisc_q (tlbmisc_q),
        .badaddr_q (badaddr_q),
        .ea_q      (ea_q),
        .ba_q      (ba_q),
        .npc_q     (next_pc),
        .npc_vld_q (next_pc_valid),
        .err_q     (class_err)
    );

    AST_DOUBLE_KEEPS_EA: assert property (@(posedge clk) disable iff (rst)
        exc_valid && exc_class == 3'd1 && status_q[BIT_EH]
        |=> $stable(ea_q) && $stable(estatus_q) && tlbmisc_q[BIT_DBL]); // R5

    AST_FAST_MISS_VEC: assert property (@(posedge clk) disable iff (rst)
        exc_valid && exc_class == 3'd1 && !status_q[BIT_EH]
        |=> next_pc_valid && next_pc == $past(vec_tlb_fast) && tlbmisc_q[BIT_WR]); // R4

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        exc_valid && exc_class == 3'd0 && !status_q[BIT_PIE]
        |=> !next_pc_valid && $stable(status_q) && $stable(ea_q)); // R2

    AST_PERM_KEEPS_TLBMISC: assert property (@(posedge clk) disable iff (rst)
        exc_valid && exc_class == 3'd2 |=> $stable(tlbmisc_q)); // R8

    AST_UNKNOWN_ERR: assert property (@(posedge clk) disable iff (rst)
        exc_valid && exc_class == 3'd7 |=> class_err && $stable(status_q) && $stable(cause_q)); // R10

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_valid;
    logic [2:0]  exc_class;
    logic [4:0]  exc_cause;
    logic [31:0] cur_pc, fault_addr, vec_general, vec_tlb_fast;
    logic        restore;
    logic [31:0] status_q, estatus_q, bstatus_q, cause_q, tlbmisc_q, badaddr_q, ea_q, ba_q, next_pc;
    logic        next_pc_valid, class_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_seq u0 (.*);

    typedef struct packed {
        logic        v;
        logic [2:0]  cls;
        logic [4:0]  cause;
        logic [31:0] pc;
        logic [31:0] addr;
        logic        rs;
        logic [31:0] st, est, bst, ea, ba, tm, cr, bad, npc;
        logic        nv, er;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        // R2 interrupt with PIE=1
        '{1'b1,3'd0,5'd1,32'h1000,32'h0,1'b0, 32'h8,32'h3,32'h0,32'h1004,32'h0,32'h0,32'h04,32'h0,32'h100,1'b1,1'b0},
        // R11 restore
        '{1'b0,3'd0,5'd0,32'h0,32'h0,1'b1, 32'h3,32'h3,32'h0,32'h1004,32'h0,32'h0,32'h04,32'h0,32'h0,1'b0,1'b0},
        // R4 fast miss
        '{1'b1,3'd1,5'd12,32'h2000,32'h0,1'b0, 32'h4,32'h3,32'h0,32'h2004,32'h0,32'h8,32'h30,32'h0,32'h200,1'b1,1'b0},
        // R5 double miss
        '{1'b1,3'd1,5'd12,32'h3000,32'h0,1'b0, 32'h4,32'h3,32'h0,32'h2004,32'h0,32'hC,32'h30,32'h0,32'h100,1'b1,1'b0},
        // R6 nested trap
        '{1'b1,3'd4,5'd3,32'h4000,32'h0,1'b0, 32'h4,32'h3,32'h0,32'h2004,32'h0,32'hC,32'h0C,32'h0,32'h100,1'b1,1'b0},
        // R11 restore
        '{1'b0,3'd0,5'd0,32'h0,32'h0,1'b1, 32'h3,32'h3,32'h0,32'h2004,32'h0,32'hC,32'h0C,32'h0,32'h0,1'b0,1'b0},
        // R7 break, EH=0
        '{1'b1,3'd5,5'd7,32'h5000,32'h0,1'b0, 32'h4,32'h3,32'h3,32'h2004,32'h5004,32'hC,32'h1C,32'h0,32'h100,1'b1,1'b0},
        // R7 break, EH=1
        '{1'b1,3'd5,5'd7,32'h6000,32'h0,1'b0, 32'h4,32'h3,32'h3,32'h2004,32'h5004,32'hC,32'h1C,32'h0,32'h100,1'b1,1'b0},
        // R8 permission fault while nested
        '{1'b1,3'd2,5'd14,32'h7000,32'h0,1'b0, 32'h4,32'h4,32'h3,32'h7004,32'h5004,32'hC,32'h38,32'h0,32'h100,1'b1,1'b0},
        // R11 restore
        '{1'b0,3'd0,5'd0,32'h0,32'h0,1'b1, 32'h4,32'h4,32'h3,32'h7004,32'h5004,32'hC,32'h38,32'h0,32'h0,1'b0,1'b0},
        // R2 masked interrupt
        '{1'b1,3'd0,5'd1,32'h7700,32'h0,1'b0, 32'h4,32'h4,32'h3,32'h7004,32'h5004,32'hC,32'h38,32'h0,32'h0,1'b0,1'b0},
        // R6 nested supervisor
        '{1'b1,3'd3,5'd9,32'h8000,32'h0,1'b0, 32'h4,32'h4,32'h3,32'h7004,32'h5004,32'hC,32'h24,32'h0,32'h100,1'b1,1'b0},
        // R9 misaligned
        '{1'b1,3'd6,5'd6,32'h8800,32'hDEADBEE1,1'b0, 32'h4,32'h4,32'h3,32'h7004,32'h5004,32'hC,32'h18,32'hDEADBEE1,32'h100,1'b1,1'b0},
        // R10 unknown class
        '{1'b1,3'd7,5'd5,32'h9900,32'h0,1'b0, 32'h4,32'h4,32'h3,32'h7004,32'h5004,32'hC,32'h18,32'hDEADBEE1,32'h0,1'b0,1'b1}
    };

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [2:0] cls, input logic [4:0] cs,
                         input logic [31:0] pc, input logic [31:0] ad, input logic rs);
        @(negedge clk);
        exc_valid = v; exc_class = cls; exc_cause = cs;
        cur_pc = pc; fault_addr = ad; restore = rs;
        @(negedge clk);
        exc_valid = 1'b0; restore = 1'b0;
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; exc_valid = 1'b0; exc_class = '0; exc_cause = '0;
        cur_pc = '0; fault_addr = '0; restore = 1'b0;
        vec_general = 32'h100; vec_tlb_fast = 32'h200;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12", "status", status_q, 32'h3);
        chk("R12", "estatus", estatus_q, 32'h0);
        chk("R12", "cause", cause_q, 32'h0);
        chk("R12", "valid", {31'd0, next_pc_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].v, TBL[i].cls, TBL[i].cause, TBL[i].pc, TBL[i].addr, TBL[i].rs);
            chk("R1/R11", "status", status_q, TBL[i].st);
            chk("R2/R4/R6", "estatus", estatus_q, TBL[i].est);
            chk("R7", "bstatus", bstatus_q, TBL[i].bst);
            chk("R2/R4/R6", "ea", ea_q, TBL[i].ea);
            chk("R7", "ba", ba_q, TBL[i].ba);
            chk("R4/R5/R8", "tlbmisc", tlbmisc_q, TBL[i].tm);
            chk("R3", "cause", cause_q, TBL[i].cr);
            chk("R9", "badaddr", badaddr_q, TBL[i].bad);
            chk("R12", "valid", {31'd0, next_pc_valid}, {31'd0, TBL[i].nv});
            chk("R10", "class_err", {31'd0, class_err}, {31'd0, TBL[i].er});
            if (TBL[i].nv) chk("R12", "next_pc", next_pc, TBL[i].npc);
        end

        // R12 valid pulse lasts one cycle
        apply(1'b1, 3'd3, 5'd9, 32'hA000, 32'h0, 1'b0);
        @(negedge clk);
        chk("R12", "valid after idle", {31'd0, next_pc_valid}, 32'h0);

        // R6 trap with EH=0 after reset
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        apply(1'b1, 3'd4, 5'd3, 32'h9000, 32'h0, 1'b0);
        chk("R6", "estatus", estatus_q, 32'h3);
        chk("R6", "ea", ea_q, 32'h9004);
        chk("R1", "status", status_q, 32'h4);

        // R11 exception wins over simultaneous restore
        apply(1'b1, 3'd3, 5'd9, 32'hA000, 32'h0, 1'b1);
        chk("R11", "status", status_q, 32'h4);
        chk("R6", "ea kept", ea_q, 32'h9004);

        // R6 supervisor with EH=0
        apply(1'b0, 3'd0, 5'd0, 32'h0, 32'h0, 1'b1);
        chk("R11", "status", status_q, 32'h3);
        apply(1'b1, 3'd3, 5'd9, 32'hB000, 32'h0, 1'b0);
        chk("R6", "ea", ea_q, 32'hB004);
        chk("R3", "cause", cause_q, 32'h24);
        chk("R6", "next_pc", next_pc, 32'h100);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule